// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers the interrupt sources of a storage host controller. A 32-bit pending-status register and a 32-bit mask register are each reached as two 16-bit halves over a small register bus. Hardware raises status bits through a one-cycle event strobe that carries a bit index. Software acknowledges bits by writing zeros to them. A set mask bit blocks its source. The block drives a single-clock interrupt pulse toward the system interrupt controller.

A second, 16-bit card-interrupt group has its own control, status and mask registers. When enabled, it mirrors the attached device's interrupt line into its status bit 0. It pulses the main interrupt output together with a dedicated data-line-1 interrupt output.

Both pulses are edge-style. They fire only when the set of unmasked pending bits goes from empty to non-empty. The test is made on every update, whether the update is a new event, a status clear or a mask rewrite.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the registers read as follows: status low half (address 0) holds only the presence bits, status high half (address 1) reads 0, mask low (address 2) reads 0x031D, mask high (address 3) reads 0x8B7F, card control (address 4) reads 0, card status (address 5) reads 0 and card mask (address 6) reads 0xC007. No pulse is raised.
- R2: Only bits 0x031D of the low half and 0x8B7F of the high half are implemented. Status and mask reads return only those bits, mask writes keep only those bits, and events that name an unimplemented index change nothing.
- R3: A write to status address 0 or 1 ANDs the written value into that 16-bit half. Written zeros clear bits, written ones leave bits unchanged, and the other half is not touched.
- R4: An event strobe with index k sets status bit k (bits 0 to 15 in the low half, bits 16 to 31 in the high half). When a bus clear of bit k arrives in the same cycle, the set wins.
- R5: When an event takes the unmasked pending set from empty to non-empty, irq_pulse is high for exactly the one clock after the edge that took the event.
- R6: An event on a masked bit, or an event that arrives while an unmasked bit is already pending, raises no pulse.
- R7: A mask write that unmasks a pending bit while nothing else is unmasked and pending raises one pulse. A mask write made while an unmasked bit is already pending raises none.
- R8: A read of status address 0 ORs in 0x00B0 when card_present is 1 and 0x0008 when it is 0.
- R9: Card control writes keep bits 0x0305 and card mask writes keep bits 0xC007. While card control bit 0 is set, card status bit 0 follows card_irq_line. While it is clear, the line is ignored.
- R10: When the unmasked card pending set goes from empty to non-empty, irq_pulse and dat1_pulse are both high for that one clock.
- R11: A write to card status (address 5) ANDs the written value into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select, used for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| evt_set | input | 1 | One-cycle hardware event strobe |
| evt_idx | input | 5 | Status bit index named by the event |
| card_present | input | 1 | Card inserted indication |
| card_irq_line | input | 1 | Device interrupt line |
| irq_pulse | output | 1 | Main interrupt pulse |
| dat1_pulse | output | 1 | Data-line-1 interrupt pulse |

## Verification
The bench sweeps all 32 event indices twice: once with everything unmasked and once with everything masked followed by an unmask write. This catches a design that pulses on a blocked bit or stores an unimplemented one. It also catches a design that fails to re-evaluate on a mask write, which would leave a pending unmasked source silent forever. Further cases cover a clear and a set of the same bit in one cycle, a second event while a bit is already pending (a level-style design would pulse again or hold the output high), and a half write that disturbs the other half. The card group is driven with its enable both clear and set, which exposes a design that mirrors the line while disabled or that fails to raise the data-line-1 pulse.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int HALF_W = 16;
  localparam int FULL_W = 2 * HALF_W;
  localparam int IDX_W  = $clog2(FULL_W);
  localparam int ADDR_W = 3;

  localparam logic [FULL_W-1:0] IMPL_BITS   = 32'h8B7F_031D;
  localparam logic [FULL_W-1:0] MASK_RST    = 32'h8B7F_031D;
  localparam logic [HALF_W-1:0] CARD_CTL_KEEP  = 16'h0305;
  localparam logic [HALF_W-1:0] CARD_MASK_KEEP = 16'hC007;
  localparam logic [HALF_W-1:0] PRESENT_BITS   = 16'h00B0;
  localparam logic [HALF_W-1:0] ABSENT_BITS    = 16'h0008;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT_LO  = 3'd0,
    SEL_STAT_HI  = 3'd1,
    SEL_MASK_LO  = 3'd2,
    SEL_MASK_HI  = 3'd3,
    SEL_CARD_CTL = 3'd4,
    SEL_CARD_ST  = 3'd5,
    SEL_CARD_MSK = 3'd6
  } reg_sel_e;

  // one-hot of the event bit, limited to implemented positions
  function automatic logic [FULL_W-1:0] event_vec(input logic en, input logic [IDX_W-1:0] idx);
    logic [FULL_W-1:0] v;
    v = '0;
    if (en) v[idx] = 1'b1;
    return v & IMPL_BITS;
  endfunction

  // AND-mask for a status half write: ones everywhere except the written half
  function automatic logic [FULL_W-1:0] clear_and(input logic wr_lo, input logic wr_hi,
                                                  input logic [HALF_W-1:0] val);
    return {wr_hi ? val : {HALF_W{1'b1}}, wr_lo ? val : {HALF_W{1'b1}}};
  endfunction
endpackage

// File: rtl/irq_main_regs.sv
module irq_main_regs
  import irq_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stat_lo,
  input  logic                wr_stat_hi,
  input  logic                wr_mask_lo,
  input  logic                wr_mask_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                evt_set,
  input  logic [IDX_W-1:0]    evt_idx,
  output logic [FULL_W-1:0]   stat_q,
  output logic [FULL_W-1:0]   mask_q,
  output logic [FULL_W-1:0]   pend_old,
  output logic [FULL_W-1:0]   pend_new
);
  logic [FULL_W-1:0] stat_d, mask_d;

  always_comb begin
    stat_d = (stat_q & clear_and(wr_stat_lo, wr_stat_hi, wdata)) | event_vec(evt_set, evt_idx);
    mask_d = mask_q;
    if (wr_mask_lo) mask_d[HALF_W-1:0]      = wdata & IMPL_BITS[HALF_W-1:0];
    if (wr_mask_hi) mask_d[FULL_W-1:HALF_W] = wdata & IMPL_BITS[FULL_W-1:HALF_W];
  end

  assign pend_old = stat_q & ~mask_q;
  assign pend_new = stat_d & ~mask_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irq_card_regs.sv
module irq_card_regs
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic [HALF_W-1:0] wdata,
  input  logic              line,
  output logic [HALF_W-1:0] ctl_q,
  output logic [HALF_W-1:0] cstat_q,
  output logic [HALF_W-1:0] cmask_q,
  output logic [HALF_W-1:0] cpend_old,
  output logic [HALF_W-1:0] cpend_new
);
  logic [HALF_W-1:0] ctl_d, cstat_d, cmask_d;

  always_comb begin
    ctl_d   = wr_ctl  ? (wdata & CARD_CTL_KEEP)  : ctl_q;
    cmask_d = wr_mask ? (wdata & CARD_MASK_KEEP) : cmask_q;
    cstat_d = wr_stat ? (cstat_q & wdata) : cstat_q;
    if (ctl_d[0]) cstat_d[0] = line;
  end

  assign cpend_old = cstat_q & ~cmask_q;
  assign cpend_new = cstat_d & ~cmask_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cstat_q <= '0;
      cmask_q <= CARD_MASK_KEEP;
    end else begin
      ctl_q   <= ctl_d;
      cstat_q <= cstat_d;
      cmask_q <= cmask_d;
    end
  end
endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int W = 32
) (
  input  logic [W-1:0] pend_old,
  input  logic [W-1:0] pend_new,
  output logic         rise
);
  assign rise = (pend_old == '0) && (pend_new != '0);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              evt_set,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic              card_present,
  input  logic              card_irq_line,
  output logic              irq_pulse,
  output logic              dat1_pulse
);
  logic [FULL_W-1:0] stat_q, mask_q, pend_old, pend_new;
  logic [HALF_W-1:0] ctl_q, cstat_q, cmask_q, cpend_old, cpend_new;
  logic main_rise, card_rise;
  logic irq_q, dat1_q;

  logic wr_stat_lo, wr_stat_hi, wr_mask_lo, wr_mask_hi, wr_cctl, wr_cst, wr_cmsk;
  assign wr_stat_lo = bus_wr && (bus_addr == SEL_STAT_LO);
  assign wr_stat_hi = bus_wr && (bus_addr == SEL_STAT_HI);
  assign wr_mask_lo = bus_wr && (bus_addr == SEL_MASK_LO);
  assign wr_mask_hi = bus_wr && (bus_addr == SEL_MASK_HI);
  assign wr_cctl    = bus_wr && (bus_addr == SEL_CARD_CTL);
  assign wr_cst     = bus_wr && (bus_addr == SEL_CARD_ST);
  assign wr_cmsk    = bus_wr && (bus_addr == SEL_CARD_MSK);

  irq_main_regs u_main (
    .clk, .rst_n, .wr_stat_lo, .wr_stat_hi, .wr_mask_lo, .wr_mask_hi,
    .wdata(bus_wdata), .evt_set, .evt_idx,
    .stat_q, .mask_q, .pend_old, .pend_new
  );

  irq_card_regs u_card (
    .clk, .rst_n, .wr_ctl(wr_cctl), .wr_stat(wr_cst), .wr_mask(wr_cmsk),
    .wdata(bus_wdata), .line(card_irq_line),
    .ctl_q, .cstat_q, .cmask_q, .cpend_old, .cpend_new
  );

  irq_rise_det #(.W(FULL_W)) u_main_rise (.pend_old(pend_old),  .pend_new(pend_new),  .rise(main_rise));
  irq_rise_det #(.W(HALF_W)) u_card_rise (.pend_old(cpend_old), .pend_new(cpend_new), .rise(card_rise));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      dat1_q <= 1'b0;
    end else begin
      irq_q  <= main_rise | card_rise;
      dat1_q <= card_rise;
    end
  end

  assign irq_pulse  = irq_q;
  assign dat1_pulse = dat1_q;

  always_comb begin
    unique case (bus_addr)
      SEL_STAT_LO:  bus_rdata = (stat_q[HALF_W-1:0] & IMPL_BITS[HALF_W-1:0])
                              | (card_present ? PRESENT_BITS : ABSENT_BITS);
      SEL_STAT_HI:  bus_rdata = stat_q[FULL_W-1:HALF_W] & IMPL_BITS[FULL_W-1:HALF_W];
      SEL_MASK_LO:  bus_rdata = mask_q[HALF_W-1:0];
      SEL_MASK_HI:  bus_rdata = mask_q[FULL_W-1:HALF_W];
      SEL_CARD_CTL: bus_rdata = ctl_q;
      SEL_CARD_ST:  bus_rdata = cstat_q;
      SEL_CARD_MSK: bus_rdata = cmask_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              evt_set,
  input logic [IDX_W-1:0]  evt_idx,
  input logic [FULL_W-1:0] stat_q,
  input logic [FULL_W-1:0] mask_q,
  input logic              card_rise,
  input logic              irq_pulse,
  input logic              dat1_pulse
);
  // R2: no unimplemented bit is ever held in status or mask
  assert_impl_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | mask_q) & ~IMPL_BITS) == '0);

  // R5: unmasked event on an idle set gives a pulse one clock later
  assert_evt_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set && !bus_wr && IMPL_BITS[evt_idx] && !mask_q[evt_idx] && ((stat_q & ~mask_q) == '0))
    |=> irq_pulse);

  // R6: with something already pending, only the card group can pulse
  assert_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_q & ~mask_q) != '0) && !card_rise) |=> !irq_pulse);

  // R10: data-line-1 pulse comes with the main pulse and lasts one clock
  assert_dat1_main_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat1_pulse |-> irq_pulse);
  assert_dat1_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat1_pulse |=> !dat1_pulse);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .evt_set(evt_set), .evt_idx(evt_idx),
  .stat_q(stat_q), .mask_q(mask_q), .card_rise(card_rise),
  .irq_pulse(irq_pulse), .dat1_pulse(dat1_pulse)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, evt_set = 1'b0, card_present = 1'b0, card_irq_line = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [4:0] evt_idx = '0;
  logic irq_pulse, dat1_pulse;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic got_irq, got_dat1;
  localparam logic [31:0] IMPL = 32'h8B7F_031D;

  always #2.5 clk = ~clk;

  irq_status_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; #0.5; v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; got_irq = irq_pulse; got_dat1 = dat1_pulse;
  endtask

  task automatic evt(input logic [4:0] i);
    @(negedge clk); evt_set = 1; evt_idx = i;
    @(negedge clk); evt_set = 0; got_irq = irq_pulse; got_dat1 = dat1_pulse;
  endtask

  task automatic line(input logic v);
    @(negedge clk); card_irq_line = v;
    @(negedge clk); got_irq = irq_pulse; got_dat1 = dat1_pulse;
  endtask

  function automatic logic [15:0] lo_read(input logic [31:0] s, input logic pres);
    return (s[15:0] & IMPL[15:0]) | (pres ? 16'h00B0 : 16'h0008);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(0, v); chk("R1 stat lo", v, 16'h0008);
    rd(1, v); chk("R1 stat hi", v, 0);
    rd(2, v); chk("R1 mask lo", v, 16'h031D);
    rd(3, v); chk("R1 mask hi", v, 16'h8B7F);
    rd(4, v); chk("R1 card ctl", v, 0);
    rd(5, v); chk("R1 card stat", v, 0);
    rd(6, v); chk("R1 card mask", v, 16'hC007);
    chk("R1 no pulse", {irq_pulse, dat1_pulse}, 0);
    // R8 presence bits
    card_present = 1; rd(0, v); chk("R8 present", v, 16'h00B0);
    card_present = 0; rd(0, v); chk("R8 absent", v, 16'h0008);

    // sweep all indices
    for (int i = 0; i < 32; i++) begin
      logic imp;
      logic [31:0] bit_v;
      logic [2:0] half;
      imp = IMPL[i];
      bit_v = imp ? (32'd1 << i) : 32'd0;
      half = (i < 16) ? 3'd0 : 3'd1;
      wr(2, 16'h0000); wr(3, 16'h0000);
      chk("R7 unmask idle no pulse", got_irq, 0);
      evt(i[4:0]);
      chk($sformatf("R5 pulse idx %0d", i), got_irq, imp);
      @(negedge clk); chk("R5 one clock", irq_pulse, 0);
      rd(0, v); chk($sformatf("R4 R2 lo idx %0d", i), v, lo_read(bit_v, 0));
      rd(1, v); chk($sformatf("R4 R2 hi idx %0d", i), v, bit_v[31:16]);
      wr(half, 16'h0000);
      rd(0, v); chk("R3 cleared lo", v, lo_read(0, 0));
      rd(1, v); chk("R3 cleared hi", v, 0);
      wr(2, 16'hFFFF); wr(3, 16'hFFFF);
      rd(2, v); chk("R2 mask lo keep", v, 16'h031D);
      rd(3, v); chk("R2 mask hi keep", v, 16'h8B7F);
      evt(i[4:0]);
      chk($sformatf("R6 masked idx %0d", i), got_irq, 0);
      wr(half + 3'd2, 16'h0000);
      chk($sformatf("R7 unmask idx %0d", i), got_irq, imp);
      wr(half, 16'h0000);
    end

    // R3 half isolation, R6 already pending
    wr(2, 0); wr(3, 0);
    evt(0); chk("R5 bit0", got_irq, 1);
    evt(2); chk("R6 second event", got_irq, 0);
    evt(16); chk("R6 third event", got_irq, 0);
    wr(0, 16'hFFFB);
    rd(0, v); chk("R3 lo partial", v, lo_read(32'h1, 0));
    rd(1, v); chk("R3 hi untouched", v, 16'h0001);
    // R4 set wins over clear
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 0; evt_set = 1; evt_idx = 0;
    @(negedge clk); bus_wr = 0; evt_set = 0;
    rd(0, v); chk("R4 set wins", v, lo_read(32'h1, 0));
    // R7 mask write with other pending: mask bit2, set it, unmask -> no pulse
    wr(2, 16'h0004); evt(2);
    wr(2, 16'h0000); chk("R7 unmask while pending", got_irq, 0);
    wr(0, 0); wr(1, 0);

    // card group
    wr(4, 16'hFFFF); rd(4, v); chk("R9 ctl keep", v, 16'h0305);
    line(1); chk("R10 masked card", got_irq, 0);
    rd(5, v); chk("R9 follow line", v, 1);
    line(0); rd(5, v); chk("R9 follow low", v, 0);
    wr(6, 16'hFFF8); rd(6, v); chk("R9 mask keep", v, 16'hC000);
    line(1); chk("R10 irq", got_irq, 1); chk("R10 dat1", got_dat1, 1);
    @(negedge clk); chk("R10 one clock", {irq_pulse, dat1_pulse}, 0);
    wr(4, 0); rd(5, v); chk("R9 held", v, 1);
    wr(5, 16'hFFFF); rd(5, v); chk("R11 and ones", v, 1);
    wr(5, 16'h0000); rd(5, v); chk("R11 and zero", v, 0);
    line(0); line(1); chk("R9 disabled no pulse", got_dat1, 0);
    rd(5, v); chk("R9 line ignored", v, 0);
    wr(4, 1); chk("R10 enable pulses", got_dat1, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule